// File: doc/BRIEF.md
# CCD Windowed Readout Sequencer

This block is the frame-level controller for a two-output interline CCD. For each frame it picks one of eight readout modes: full frame, a central band of columns, a central band of rows, or both windows together. Each of these comes in a one-output and a two-output form. It then hands a line timing block a short ordered program of line commands. Each command carries a repeat count. The line timing block runs the whole command, including all of its repeats, and then answers with a one-cycle `seg_done`. For the whole frame the sequencer also holds the horizontal clock count per line, the two dump gate enables and the output select steady.

Frames run back to back while `run_cont` is high. With `run_cont` low, each `start` pulse runs one frame. The mode and the overclock-line enable are captured only when a frame begins. A change made during a frame is therefore picked up by the next frame.

The controller is a four-state machine:

- **IDLE**: waiting. It goes to ISSUE on `start` or `run_cont` (the *frame-go* transition) and captures the configuration on that edge.
- **ISSUE**: looks up the current program step. A step with a non-zero count moves to WAIT (*issue* transition). An empty step moves on to the next step, or to FINISH if it is the last step (*skip* transition).
- **WAIT**: holds the issued command until `seg_done`. It then goes to ISSUE for the next step (*advance* transition), or to FINISH after the last step (*complete* transition).
- **FINISH**: emits the end-of-frame pulse. It returns to ISSUE with a fresh capture when `run_cont` is high (*repeat* transition), and to IDLE otherwise (*stop* transition).

Top module: `ccd_win_seq`

## Requirements
- R1: After reset, `cmd_req`, `frame_done`, `busy`, `dump_outer` and `dump_center` are all low, and no command appears until a frame is started.
- R2: The mode code has three bits. With bit 2 = 0 the frame issues code 0 (full photodiode transfer) ×1, then code 3 (shift plus readout) ×492. When the overclock enable is set, code 2 (readout only) ×4 follows.
- R3: With mode bit 2 = 1 the frame issues code 1 (central-row photodiode transfer) ×1, then code 2 ×1, then code 2 ×4 only when the overclock enable is set, then code 3 ×163.
- R4: `hpix` is 708 for one output at full width and 360 for two outputs at full width. When mode bit 1 is set it is 246 for one output and 120 for two outputs.
- R5: `dump_outer` equals mode bit 1 (column windowing) for the whole frame, and `dump_center` is low at all times.
- R6: `dual_sel` equals mode bit 0 for the whole frame.
- R7: Each command is presented with exactly one single-cycle `cmd_req`. No further `cmd_req` comes until `seg_done` has been seen for it. A `seg_done` that arrives while no command is outstanding has no effect.
- R8: `frame_done` is a single-cycle pulse that follows the `seg_done` of the last non-empty command. It never coincides with `cmd_req`.
- R9: With `run_cont` low, a `start` pulse runs exactly one frame and the block then returns to idle with `busy` low. A `start` during a frame is ignored.
- R10: While `run_cont` is high, frames follow one another without a start pulse. Clearing `run_cont` during a frame lets that frame finish, and no new frame begins.
- R11: `mode_i` and `ovc_en_i` are sampled only when a frame begins. Changes made during a frame first affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one frame when idle |
| run_cont | input | 1 | Run frames back to back |
| mode_i | input | 3 | Bit 0 dual output, bit 1 column window, bit 2 row window |
| ovc_en_i | input | 1 | Add the four readout-only overclock lines |
| seg_done | input | 1 | Line timing block finished the current command |
| cmd_req | output | 1 | One-cycle strobe: new command valid |
| cmd_code | output | 2 | Line command code (0..3) |
| cmd_reps | output | 10 | Repeat count of the command |
| hpix | output | 10 | Horizontal clock cycles per line |
| dump_outer | output | 1 | Outer-column dump gate enable |
| dump_center | output | 1 | Central-column dump gate enable (held low) |
| dual_sel | output | 1 | Two-output readout select |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | A frame is in progress |

## Verification
The hardest situation to reach is a configuration change that lands while a frame is already running. A wrong design could pick it up mid-program and mix steps from two modes, which the frame's result would only show as a subtly wrong sequence. The bench waits until the first command of a frame has been observed, changes `mode_i` and `ovc_en_i` at that point, and queues the old mode's program for the current frame and the new one for the next. In continuous mode it does the same across two frame boundaries, and it drops `run_cont` in the middle of the last frame to show that the frame still completes. Stray `seg_done` and `start` pulses sent while idle or in the middle of a frame cover the ignored-input cases.

// File: rtl/ccd_win_pkg.sv
package ccd_win_pkg;

    typedef enum logic [1:0] {
        LC_PD_FULL = 2'd0,
        LC_PD_CTR  = 2'd1,
        LC_READ    = 2'd2,
        LC_SHIFT   = 2'd3
    } line_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FINISH
    } seq_state_e;

endpackage

// File: rtl/ccd_win_prog.sv
module ccd_win_prog
    import ccd_win_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int STEP_W    = 2,
    parameter int ROWS_FULL = 492,
    parameter int ROWS_CTR  = 163,
    parameter int OVC_LINES = 4
) (
    input  logic [2:0]        mode,
    input  logic              ovc,
    input  logic [STEP_W-1:0] step,
    output line_cmd_e         code,
    output logic [CNT_W-1:0]  reps
);

    logic row_win;
    assign row_win = mode[2];

    always_comb begin
        code = LC_SHIFT;
        reps = '0;
        unique case (step)
            STEP_W'(0): begin
                code = row_win ? LC_PD_CTR : LC_PD_FULL;
                reps = CNT_W'(1);
            end
            STEP_W'(1): begin
                code = row_win ? LC_READ : LC_SHIFT;
                reps = row_win ? CNT_W'(1) : CNT_W'(ROWS_FULL);
            end
            STEP_W'(2): begin
                code = LC_READ;
                reps = ovc ? CNT_W'(OVC_LINES) : '0;
            end
            default: begin
                code = LC_SHIFT;
                reps = row_win ? CNT_W'(ROWS_CTR) : '0;
            end
        endcase
    end

endmodule

// File: rtl/ccd_win_cfg.sv
module ccd_win_cfg #(
    parameter int HPIX_W      = 10,
    parameter int HPIX_FULL_S = 708,
    parameter int HPIX_FULL_D = 360,
    parameter int HPIX_COL_S  = 246,
    parameter int HPIX_COL_D  = 120
) (
    input  logic [2:0]        mode,
    output logic [HPIX_W-1:0] hpix,
    output logic              dump_outer,
    output logic              dump_center,
    output logic              dual_sel
);

    always_comb begin
        dual_sel    = mode[0];
        dump_outer  = mode[1];
        dump_center = 1'b0;
        unique case (mode[1:0])
            2'b00:   hpix = HPIX_W'(HPIX_FULL_S);
            2'b01:   hpix = HPIX_W'(HPIX_FULL_D);
            2'b10:   hpix = HPIX_W'(HPIX_COL_S);
            default: hpix = HPIX_W'(HPIX_COL_D);
        endcase
    end

endmodule

// File: rtl/ccd_win_fsm.sv
module ccd_win_fsm
    import ccd_win_pkg::*;
#(
    parameter int CNT_W  = 10,
    parameter int STEP_W = 2,
    parameter int NSTEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run_cont,
    input  logic              seg_done,
    input  logic [2:0]        mode_i,
    input  logic              ovc_en_i,
    input  line_cmd_e         prog_code,
    input  logic [CNT_W-1:0]  prog_reps,
    output logic [STEP_W-1:0] step,
    output logic [2:0]        mode_q,
    output logic              ovc_q,
    output logic              cmd_req,
    output line_cmd_e         cmd_code,
    output logic [CNT_W-1:0]  cmd_reps,
    output logic              frame_done,
    output logic              busy
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

    seq_state_e state, state_n;
    logic       frame_go;
    logic       last;
    logic       empty;
    logic       advance;

    assign last     = (step == LAST_STEP);
    assign empty    = (prog_reps == '0);
    assign frame_go = ((state == S_IDLE) && (start || run_cont)) ||
                      ((state == S_FINISH) && run_cont);
    assign advance  = !last && (((state == S_ISSUE) && empty) ||
                                ((state == S_WAIT) && seg_done));

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   state_n = frame_go ? S_ISSUE : S_IDLE;
            S_ISSUE:  state_n = !empty ? S_WAIT : (last ? S_FINISH : S_ISSUE);
            S_WAIT:   state_n = seg_done ? (last ? S_FINISH : S_ISSUE) : S_WAIT;
            S_FINISH: state_n = run_cont ? S_ISSUE : S_IDLE;
        endcase
    end

    // State register together with the frame context it tracks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            step   <= '0;
            mode_q <= '0;
            ovc_q  <= 1'b0;
        end else begin
            state <= state_n;
            if (frame_go) begin
                mode_q <= mode_i;
                ovc_q  <= ovc_en_i;
                step   <= '0;
            end else if (advance) begin
                step <= step + STEP_W'(1);
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_req    <= 1'b0;
            cmd_code   <= LC_PD_FULL;
            cmd_reps   <= '0;
            frame_done <= 1'b0;
            busy       <= 1'b0;
        end else begin
            cmd_req    <= (state == S_ISSUE) && !empty;
            frame_done <= (state == S_FINISH);
            busy       <= (state_n != S_IDLE);
            if ((state == S_ISSUE) && !empty) begin
                cmd_code <= prog_code;
                cmd_reps <= prog_reps;
            end
        end
    end

endmodule

// File: rtl/ccd_win_seq.sv
module ccd_win_seq
    import ccd_win_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int HPIX_W      = 10,
    parameter int ROWS_FULL   = 492,
    parameter int ROWS_CTR    = 163,
    parameter int OVC_LINES   = 4,
    parameter int HPIX_FULL_S = 708,
    parameter int HPIX_FULL_D = 360,
    parameter int HPIX_COL_S  = 246,
    parameter int HPIX_COL_D  = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run_cont,
    input  logic [2:0]        mode_i,
    input  logic              ovc_en_i,
    input  logic              seg_done,
    output logic              cmd_req,
    output logic [1:0]        cmd_code,
    output logic [CNT_W-1:0]  cmd_reps,
    output logic [HPIX_W-1:0] hpix,
    output logic              dump_outer,
    output logic              dump_center,
    output logic              dual_sel,
    output logic              frame_done,
    output logic              busy
);

    localparam int NSTEP  = 4;
    localparam int STEP_W = $clog2(NSTEP);

    logic [STEP_W-1:0] step;
    logic [2:0]        mode_q;
    logic              ovc_q;
    line_cmd_e         prog_code;
    logic [CNT_W-1:0]  prog_reps;
    line_cmd_e         code_q;

    ccd_win_prog #(
        .CNT_W(CNT_W), .STEP_W(STEP_W), .ROWS_FULL(ROWS_FULL),
        .ROWS_CTR(ROWS_CTR), .OVC_LINES(OVC_LINES)
    ) u_prog (
        .mode(mode_q), .ovc(ovc_q), .step(step),
        .code(prog_code), .reps(prog_reps)
    );

    ccd_win_fsm #(
        .CNT_W(CNT_W), .STEP_W(STEP_W), .NSTEP(NSTEP)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .run_cont(run_cont),
        .seg_done(seg_done), .mode_i(mode_i), .ovc_en_i(ovc_en_i),
        .prog_code(prog_code), .prog_reps(prog_reps),
        .step(step), .mode_q(mode_q), .ovc_q(ovc_q),
        .cmd_req(cmd_req), .cmd_code(code_q), .cmd_reps(cmd_reps),
        .frame_done(frame_done), .busy(busy)
    );

    ccd_win_cfg #(
        .HPIX_W(HPIX_W), .HPIX_FULL_S(HPIX_FULL_S), .HPIX_FULL_D(HPIX_FULL_D),
        .HPIX_COL_S(HPIX_COL_S), .HPIX_COL_D(HPIX_COL_D)
    ) u_cfg (
        .mode(mode_q), .hpix(hpix), .dump_outer(dump_outer),
        .dump_center(dump_center), .dual_sel(dual_sel)
    );

    assign cmd_code = code_q;

endmodule

// File: rtl/ccd_win_seq_chk.sv
module ccd_win_seq_chk #(
    parameter int CNT_W       = 10,
    parameter int HPIX_W      = 10,
    parameter int HPIX_FULL_S = 708,
    parameter int HPIX_FULL_D = 360,
    parameter int HPIX_COL_S  = 246,
    parameter int HPIX_COL_D  = 120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_req,
    input logic [CNT_W-1:0]  cmd_reps,
    input logic [HPIX_W-1:0] hpix,
    input logic              dump_outer,
    input logic              dump_center,
    input logic              dual_sel,
    input logic              frame_done,
    input logic              busy
);

    a_r5_center_dump_low: assert property (@(posedge clk) disable iff (!rst_n)
        !dump_center);

    a_r5_outer_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && dump_outer) |-> (hpix == HPIX_W'(HPIX_COL_S) || hpix == HPIX_W'(HPIX_COL_D)));

    a_r6_dual_pix: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && dual_sel) |-> (hpix == HPIX_W'(HPIX_FULL_D) || hpix == HPIX_W'(HPIX_COL_D)));

    a_r4_pix_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> (hpix == HPIX_W'(HPIX_FULL_S) || hpix == HPIX_W'(HPIX_FULL_D) ||
                     hpix == HPIX_W'(HPIX_COL_S)  || hpix == HPIX_W'(HPIX_COL_D)));

    a_r7_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);

    a_r7_reps_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |-> (cmd_reps != '0));

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && cmd_req));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_req);

endmodule

bind ccd_win_seq ccd_win_seq_chk #(
    .CNT_W(CNT_W), .HPIX_W(HPIX_W), .HPIX_FULL_S(HPIX_FULL_S),
    .HPIX_FULL_D(HPIX_FULL_D), .HPIX_COL_S(HPIX_COL_S), .HPIX_COL_D(HPIX_COL_D)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_reps(cmd_reps),
    .hpix(hpix), .dump_outer(dump_outer), .dump_center(dump_center),
    .dual_sel(dual_sel), .frame_done(frame_done), .busy(busy)
);

// File: tb/tb_ccd_win_seq.sv
module tb_ccd_win_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       run_cont = 1'b0;
    logic [2:0] mode_i = 3'd0;
    logic       ovc_en_i = 1'b0;
    logic       resp_done = 1'b0;
    logic       stray_done = 1'b0;
    logic       seg_done;
    logic       cmd_req;
    logic [1:0] cmd_code;
    logic [9:0] cmd_reps;
    logic [9:0] hpix;
    logic       dump_outer, dump_center, dual_sel, frame_done, busy;

    assign seg_done = resp_done | stray_done;

    always #10 clk = ~clk;

    ccd_win_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .run_cont(run_cont),
        .mode_i(mode_i), .ovc_en_i(ovc_en_i), .seg_done(seg_done),
        .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_reps(cmd_reps),
        .hpix(hpix), .dump_outer(dump_outer), .dump_center(dump_center),
        .dual_sel(dual_sel), .frame_done(frame_done), .busy(busy)
    );

    typedef struct {
        int code;   // -1 marks end of frame
        int reps;
        int hp;
        int dmp;
        int dual;
    } exp_t;

    exp_t exp_q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   req_cnt = 0;
    int   done_cnt = 0;
    int   frame_cnt = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic push_cmd(input int c, input int r, input int m);
        exp_t e;
        e.code = c;
        e.reps = r;
        e.hp   = m[1] ? (m[0] ? 120 : 246) : (m[0] ? 360 : 708);
        e.dmp  = m[1];
        e.dual = m[0];
        exp_q.push_back(e);
    endtask

    // Driver side of the scoreboard: expected program from R2/R3/R4/R5/R6
    task automatic push_frame(input int m, input bit ovc);
        exp_t e;
        if (m[2]) begin
            push_cmd(1, 1, m);
            push_cmd(2, 1, m);
            if (ovc) push_cmd(2, 4, m);
            push_cmd(3, 163, m);
        end else begin
            push_cmd(0, 1, m);
            push_cmd(3, 492, m);
            if (ovc) push_cmd(2, 4, m);
        end
        e.code = -1; e.reps = 0; e.hp = 0; e.dmp = 0; e.dual = 0;
        exp_q.push_back(e);
    endtask

    // Line timing model: answers each command after a few cycles
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_req) begin
                repeat (3) @(negedge clk);
                resp_done = 1'b1;
                @(negedge clk);
                resp_done = 1'b0;
            end
        end
    end

    always @(posedge clk) if (rst_n && resp_done) done_cnt <= done_cnt + 1;

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (dump_center) check(1'b0, "R5 center dump", 1, 0);
            if (cmd_req) begin
                check(req_cnt == done_cnt, "R7 request before previous done", req_cnt, done_cnt);
                req_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected command", int'(cmd_code), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.code >= 0, "R8 command where frame end expected", int'(cmd_code), e.code);
                    check(int'(cmd_code) == e.code, "R2 R3 command code", int'(cmd_code), e.code);
                    check(int'(cmd_reps) == e.reps, "R2 R3 repeat count", int'(cmd_reps), e.reps);
                    check(int'(hpix) == e.hp, "R4 pixels per line", int'(hpix), e.hp);
                    check(int'(dump_outer) == e.dmp, "R5 outer dump", int'(dump_outer), e.dmp);
                    check(int'(dual_sel) == e.dual, "R6 dual select", int'(dual_sel), e.dual);
                end
            end
            if (frame_done) begin
                frame_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected frame end", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.code == -1, "R8 frame end too early", -1, e.code);
                end
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int f0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!cmd_req && !frame_done && !busy, "R1 reset outputs quiet",
              int'({cmd_req, frame_done, busy}), 0);
        check(!dump_outer && !dump_center, "R1 dump gates low", int'({dump_outer, dump_center}), 0);

        // R7 stray done while idle has no effect
        @(negedge clk); stray_done = 1'b1;
        @(negedge clk); stray_done = 1'b0;
        repeat (10) @(negedge clk);
        check(req_cnt == 0 && !busy, "R7 stray done ignored", req_cnt, 0);

        // R9 R11: single frames in every mode, config changed mid-frame
        for (int m = 0; m < 8; m++) begin
            bit ov;
            ov = m[0] ^ m[1] ^ m[2];
            mode_i = 3'(m); ovc_en_i = ov;
            push_frame(m, ov);
            f0 = frame_cnt; r0 = req_cnt;
            pulse_start();
            wait (req_cnt > r0);
            @(negedge clk);
            mode_i = ~3'(m); ovc_en_i = !ov;     // R11 must not affect this frame
            if (m == 3) pulse_start();           // R9 start during a frame ignored
            @(negedge clk); stray_done = 1'b0;
            wait (frame_cnt > f0);
            repeat (12) @(negedge clk);
            check(!busy, "R9 idle after single frame", int'(busy), 0);
            check(frame_cnt == f0 + 1, "R9 exactly one frame", frame_cnt, f0 + 1);
        end

        // R10 R11: continuous run across three frames
        mode_i = 3'd2; ovc_en_i = 1'b1;
        push_frame(2, 1'b1);
        f0 = frame_cnt; r0 = req_cnt;
        @(negedge clk); run_cont = 1'b1;
        wait (req_cnt > r0);
        @(negedge clk);
        mode_i = 3'd5; ovc_en_i = 1'b0;
        push_frame(5, 1'b0);
        wait (frame_cnt > f0);
        r0 = req_cnt;
        wait (req_cnt > r0);
        @(negedge clk);
        mode_i = 3'd7; ovc_en_i = 1'b1;
        push_frame(7, 1'b1);
        wait (frame_cnt > f0 + 1);
        r0 = req_cnt;
        wait (req_cnt > r0);
        @(negedge clk);
        run_cont = 1'b0;                         // R10 current frame still completes
        mode_i = 3'd0;
        wait (frame_cnt > f0 + 2);
        repeat (20) @(negedge clk);
        check(frame_cnt == f0 + 3, "R10 frame count in continuous run", frame_cnt, f0 + 3);
        check(!busy, "R10 stops after clearing run", int'(busy), 0);
        check(exp_q.size() == 0, "R2 R3 all expected commands seen", exp_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule